// File: doc/BRIEF.md
# Configurable Port Input Macrocell Array

This block conditions the input pins of three 8-bit ports before they reach the programmable logic's input bus. There are 24 cells, one per pin. Each cell is set on its own to pass its pin straight through, to hold it in a level-sensitive latch, or to capture it in an edge-triggered register. The latch enable or register clock of a cell is chosen by a multiplexer. One source is a product-term enable shared by four cells: one enable covers the low nibble of a port and another covers the high nibble. The other source is the processor address strobe, which is common to all cells. With the address strobe selected, the cells can hold upper address bits for the logic array.

All cells work in the system clock domain. Enables are sampled at the clock, and register mode acts on a sampled rising edge of its enable. The cell outputs drive `pld_bus` and can also be read by the processor, one port at a time, through a read buffer. Configuration is written through a one-cycle write strobe. The mode of each cell acts as its state: PASS, LATCH and REG, with RSVD decoding as PASS. A write to the mode word moves a cell from one mode to another at the next clock edge.

Top module: `imc_array`

## Requirements
- R1: After reset, every cell is in transparent mode and uses the product-term enable, so `pld_bus` equals `pin_in`.
- R2: In transparent mode (encoding 00, and the reserved encoding 11), a cell output equals its pin in the same cycle.
- R3: In latch mode (encoding 01), while the selected enable is high, the cell output equals its pin in the same cycle.
- R4: In latch mode, while the selected enable is low, the cell output holds the pin value sampled at the last clock edge at which the enable was high. If no such edge has occurred since the cell entered latch mode, it holds the pin value sampled at the last edge in transparent mode.
- R5: In register mode (encoding 10), the cell output takes the pin value sampled at a clock edge at which the selected enable is high and was low at the previous edge.
- R6: In register mode, the output does not change at edges without such a rising enable, whatever the pin does. A cell entering register mode first holds the value it held before.
- R7: `pt_en[2p]` is the product-term enable for bits 3..0 of port p, and `pt_en[2p+1]` is the one for bits 7..4. Port p occupies `pin_in[8p+7:8p]` and `pld_bus[8p+7:8p]`.
- R8: A nibble's select bit at 0 picks its product-term enable, and at 1 picks `addr_strobe`.
- R9: `cfg_addr[2:1]` is the port index. With `cfg_addr[0]`=0, `cfg_wdata[2i+1:2i]` sets the mode of pin i. With `cfg_addr[0]`=1, `cfg_wdata[0]` is the low-nibble select bit and `cfg_wdata[1]` the high-nibble one. A write takes effect after the edge at which `cfg_we` is high.
- R10: A write with port index 3 changes no configuration.
- R11: `rd_data` equals `pld_bus[8p+7:8p]` for `rd_port` = p in 0..2, and is zero for `rd_port` = 3.
- R12: Every cell follows only its own mode and its own nibble's select, so neighbouring cells can run different modes at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 24 | Port pins, port p at bits 8p+7..8p |
| pt_en | input | 6 | Product-term enables, one per nibble |
| addr_strobe | input | 1 | Processor address strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Port index and word select |
| cfg_wdata | input | 16 | Configuration write data |
| rd_port | input | 2 | Port index for read-back |
| pld_bus | output | 24 | Cell outputs to the logic input bus |
| rd_data | output | 8 | Read-back of one port's cell outputs |

## Verification
The bench steps through a series of configurations. In each one, the mode encodings rotate across pins and ports, and the select bits rotate across nibbles. Every phase therefore puts transparent, latch, register and reserved cells next to each other, on both enable sources. In each phase, pins, product-term enables and the strobe are driven with random values for many cycles, and every output bit is compared each cycle with an arithmetic model. Random enables produce held-high, held-low and rising patterns. These tell latch following apart from latch holding and register capture apart from register holding. Differing enables per nibble expose any wrong group or source selection. A phase of writes to the unused port index, and the read of that index, check that both are ignored.

// File: rtl/imc_pkg.sv
package imc_pkg;

    // Per-cell operating mode; the reserved code behaves as pass-through.
    typedef enum logic [1:0] {
        MODE_PASS  = 2'b00,
        MODE_LATCH = 2'b01,
        MODE_REG   = 2'b10,
        MODE_RSVD  = 2'b11
    } cell_mode_e;

    // Enable source select per nibble group.
    typedef enum logic {
        SRC_PTERM  = 1'b0,
        SRC_STROBE = 1'b1
    } en_src_e;

endpackage

// File: rtl/imc_cfg_regs.sv
module imc_cfg_regs
    import imc_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int PORT_W    = 8,
    parameter int GROUP_W   = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [$clog2(NUM_PORTS+1):0]   cfg_addr,
    input  logic [2*PORT_W-1:0]            cfg_wdata,
    output logic [2*PORT_W*NUM_PORTS-1:0]  mode_flat,
    output logic [(PORT_W/GROUP_W)*NUM_PORTS-1:0] sel_flat
);
    localparam int PIDX_W = $clog2(NUM_PORTS+1);
    localparam int GPP    = PORT_W / GROUP_W;
    localparam logic [PIDX_W-1:0] LAST_PORT = PIDX_W'(NUM_PORTS-1);

    logic [NUM_PORTS-1:0][2*PORT_W-1:0] mode_q;
    logic [NUM_PORTS-1:0][GPP-1:0]      sel_q;
    logic [PIDX_W-1:0]                  wr_port;
    logic                               port_ok;
    logic                               wr_sel_word;

    assign wr_port     = cfg_addr[PIDX_W:1];
    assign wr_sel_word = cfg_addr[0];
    assign port_ok     = (wr_port <= LAST_PORT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            sel_q  <= '0;
        end else if (cfg_we && port_ok) begin
            if (wr_sel_word)
                sel_q[wr_port] <= cfg_wdata[GPP-1:0];
            else
                mode_q[wr_port] <= cfg_wdata;
        end
    end

    assign mode_flat = mode_q;
    assign sel_flat  = sel_q;

    // R10: a write naming a missing port leaves every configuration bit alone
    p_bad_port_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !port_ok) |=> ($stable(mode_flat) && $stable(sel_flat)));

    // R9: a mode write lands in the addressed port's mode word
    p_mode_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && port_ok && !wr_sel_word) |=> (mode_q[$past(wr_port)] == $past(cfg_wdata)));

endmodule

// File: rtl/imc_cell.sv
module imc_cell
    import imc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cell_mode_e mode,
    input  en_src_e    src,
    input  logic       pt_en,
    input  logic       strobe,
    input  logic       pin,
    output logic       cell_out
);
    logic en_sel;
    logic en_q;
    logic rise;
    logic store_q;
    logic store_d;

    // Enable multiplexer: product term or address strobe.
    always_comb begin
        unique case (src)
            SRC_PTERM:  en_sel = pt_en;
            SRC_STROBE: en_sel = strobe;
        endcase
    end

    assign rise = en_sel && !en_q;

    // Next held value per mode.
    always_comb begin
        unique case (mode)
            MODE_PASS, MODE_RSVD: store_d = pin;
            MODE_LATCH:           store_d = en_sel ? pin : store_q;
            MODE_REG:             store_d = rise ? pin : store_q;
        endcase
    end

    // State register: held value and previous enable.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            store_q <= store_d;
            en_q    <= en_sel;
        end
    end

    // Output process.
    always_comb begin
        unique case (mode)
            MODE_PASS, MODE_RSVD: cell_out = pin;
            MODE_LATCH:           cell_out = en_sel ? pin : store_q;
            MODE_REG:             cell_out = store_q;
        endcase
    end

    // R5: a sampled rising enable in register mode loads the pin
    p_reg_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rise) && $past(mode) == MODE_REG && mode == MODE_REG)
        |-> (cell_out == $past(pin)));

    // R6: without a rising enable the register output is steady
    p_reg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rise) && $past(mode) == MODE_REG && mode == MODE_REG)
        |-> $stable(cell_out));

    // R4: a closed latch keeps its value
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(en_sel) && !en_sel && $past(mode) == MODE_LATCH && mode == MODE_LATCH)
        |-> $stable(cell_out));

    // R4: a latch closing keeps the last pin seen while open
    p_latch_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_sel) && !en_sel && $past(mode) == MODE_LATCH && mode == MODE_LATCH)
        |-> (cell_out == $past(pin)));

endmodule

// File: rtl/imc_readbuf.sv
module imc_readbuf #(
    parameter int NUM_PORTS = 3,
    parameter int PORT_W    = 8
) (
    input  logic [NUM_PORTS*PORT_W-1:0]      bus_in,
    input  logic [$clog2(NUM_PORTS+1)-1:0]   rd_port,
    output logic [PORT_W-1:0]                rd_data
);
    localparam int PIDX_W = $clog2(NUM_PORTS+1);

    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rd_port == PIDX_W'(p))
                rd_data = bus_in[p*PORT_W +: PORT_W];
        end
    end

endmodule

// File: rtl/imc_array.sv
module imc_array
    import imc_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int PORT_W    = 8,
    parameter int GROUP_W   = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_PORTS*PORT_W-1:0]            pin_in,
    input  logic [NUM_PORTS*(PORT_W/GROUP_W)-1:0]  pt_en,
    input  logic                                   addr_strobe,
    input  logic                                   cfg_we,
    input  logic [$clog2(NUM_PORTS+1):0]           cfg_addr,
    input  logic [2*PORT_W-1:0]                    cfg_wdata,
    input  logic [$clog2(NUM_PORTS+1)-1:0]         rd_port,
    output logic [NUM_PORTS*PORT_W-1:0]            pld_bus,
    output logic [PORT_W-1:0]                      rd_data
);
    localparam int NUM_CELLS  = NUM_PORTS * PORT_W;
    localparam int NUM_GROUPS = NUM_PORTS * (PORT_W / GROUP_W);

    logic [2*NUM_CELLS-1:0] mode_flat;
    logic [NUM_GROUPS-1:0]  sel_flat;

    imc_cfg_regs #(
        .NUM_PORTS(NUM_PORTS),
        .PORT_W   (PORT_W),
        .GROUP_W  (GROUP_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .mode_flat(mode_flat),
        .sel_flat (sel_flat)
    );

    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
        localparam int GRP = c / GROUP_W;
        imc_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode    (cell_mode_e'(mode_flat[2*c +: 2])),
            .src     (en_src_e'(sel_flat[GRP])),
            .pt_en   (pt_en[GRP]),
            .strobe  (addr_strobe),
            .pin     (pin_in[c]),
            .cell_out(pld_bus[c])
        );

        // R2: transparent cells show the pin on the bus
        p_pass_through_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_flat[2*c +: 2] == 2'b00) |-> (pld_bus[c] == pin_in[c]));
    end

    imc_readbuf #(
        .NUM_PORTS(NUM_PORTS),
        .PORT_W   (PORT_W)
    ) u_rdbuf (
        .bus_in (pld_bus),
        .rd_port(rd_port),
        .rd_data(rd_data)
    );

    // R11: read-back of port 0 mirrors the low byte of the logic bus
    p_readback_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_port == '0) |-> (rd_data == pld_bus[PORT_W-1:0]));

endmodule

// File: tb/imc_array_test.sv
module imc_array_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pin_in = '0;
    logic [5:0]  pt_en = '0;
    logic        addr_strobe = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [1:0]  rd_port = '0;
    logic [23:0] pld_bus;
    logic [7:0]  rd_data;

    int total = 0;
    int bad = 0;
    string ptag = "R7 R8 R9 R12";

    always #10 clk = ~clk;

    imc_array uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pt_en(pt_en),
        .addr_strobe(addr_strobe), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rd_port(rd_port), .pld_bus(pld_bus),
        .rd_data(rd_data)
    );

    // Requirement-level model of the array.
    logic [1:0] m_mode [24];
    logic       m_sel  [6];
    logic       m_store[24];
    logic       m_prev [24];

    function automatic logic m_en(int c);
        return m_sel[c/4] ? addr_strobe : pt_en[c/4];
    endfunction

    function automatic logic m_out(int c);
        case (m_mode[c])
            2'b01:   return m_en(c) ? pin_in[c] : m_store[c];
            2'b10:   return m_store[c];
            default: return pin_in[c];
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 24; c++) begin
                m_mode[c] <= 2'b00; m_store[c] <= 1'b0; m_prev[c] <= 1'b0;
            end
            for (int g = 0; g < 6; g++) m_sel[g] <= 1'b0;
        end else begin
            for (int c = 0; c < 24; c++) begin
                case (m_mode[c])
                    2'b01:   if (m_en(c)) m_store[c] <= pin_in[c];
                    2'b10:   if (m_en(c) && !m_prev[c]) m_store[c] <= pin_in[c];
                    default: m_store[c] <= pin_in[c];
                endcase
                m_prev[c] <= m_en(c);
            end
            if (cfg_we && cfg_addr[2:1] != 2'd3) begin
                if (cfg_addr[0]) begin
                    m_sel[2*cfg_addr[2:1]]   <= cfg_wdata[0];
                    m_sel[2*cfg_addr[2:1]+1] <= cfg_wdata[1];
                end else begin
                    for (int i = 0; i < 8; i++)
                        m_mode[8*cfg_addr[2:1]+i] <= cfg_wdata[2*i +: 2];
                end
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare every output against the model (called at negedge).
    task automatic check_all();
        logic [7:0] exp_rd;
        for (int c = 0; c < 24; c++) begin
            string mt;
            case (m_mode[c])
                2'b01:   mt = m_en(c) ? "R3" : "R4";
                2'b10:   mt = "R5 R6";
                2'b11:   mt = "R2 R9";
                default: mt = "R2";
            endcase
            chk($sformatf("%s %s cell%0d", mt, ptag, c), 32'(pld_bus[c]), 32'(m_out(c)));
        end
        exp_rd = 8'h00;
        for (int b = 0; b < 8; b++)
            if (rd_port != 2'd3) exp_rd[b] = m_out(8*rd_port + b);
        chk($sformatf("R11 port%0d", rd_port), 32'(rd_data), 32'(exp_rd));
    endtask

    task automatic write_cfg(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        check_all();
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        check_all();
        cfg_we = 1'b0;
    endtask

    task automatic run_random(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check_all();
            pin_in = 24'($urandom);
            pt_en = 6'($urandom);
            addr_strobe = 1'($urandom);
            rd_port = 2'(k);
        end
    endtask

    initial begin
        #4_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        pin_in = 24'hA5C33C;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset leaves all cells transparent
        chk("R1 reset pass-through", 32'(pld_bus), 32'h00A5C33C);
        pin_in = 24'h5A0FF0;
        #1 chk("R1 R2 pass follows pin", 32'(pld_bus), 32'h005A0FF0);

        // Sweep rotating configurations (R7 R8 R9 R12).
        for (int ph = 0; ph < 12; ph++) begin
            for (int p = 0; p < 3; p++) begin
                logic [15:0] mw;
                for (int i = 0; i < 8; i++) mw[2*i +: 2] = 2'((i + ph + p) % 4);
                write_cfg({2'(p), 1'b0}, mw);
                write_cfg({2'(p), 1'b1}, 16'((ph + p) % 4));
            end
            run_random(120);
        end

        // R10: writes to port index 3 must change nothing.
        ptag = "R10";
        write_cfg(3'b110, 16'hAAAA);
        write_cfg(3'b111, 16'h0003);
        run_random(120);

        @(negedge clk);
        check_all();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule